// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block sits between a simple processor-side request port and an asynchronous DRAM that takes its address in two halves on one set of pins. A processor access is a level request with a write flag, a full address and write data. The controller splits the address into a row part (upper bits) and a column part (lower bits). It strobes the row with RAS and the column with CAS on the shared address pins. It moves the data over a bidirectional data bus and answers with a one-cycle completion pulse, which carries the read data on reads.

After an access the row stays open, with RAS held low. A later access to the same row then needs only a CAS pulse. An access to another row first closes the page, then waits out precharge and opens the new row. A free-running interval counter requests a CAS-before-RAS refresh at a fixed cadence. The refresh waits for any access in flight to finish and closes an open page before it runs. While it runs, no processor access reaches the memory. The precharge time, the RAS-to-CAS delay and the CAS pulse width are parameters counted in clock cycles.

Top module: `dram_pagectl`

## Requirements
- R1: While reset is applied, and afterwards until a request or a refresh arrives, mem_ce_n, mem_we_n, mem_ras_n and mem_cas_n are all high (inactive) and cpu_done is low.
- R2: cpu_addr is split as row = cpu_addr[AW-1:COL_W] and column = cpu_addr[COL_W-1:0]. The row sits on mem_addr when mem_ras_n falls, and the column sits on mem_addr when mem_cas_n falls.
- R3: A read of a location returns the data most recently written there. cpu_rdata is valid in the cycle in which cpu_done is high.
- R4: An access to the row that is already open causes no new RAS fall. With the request raised before clock edge 0, cpu_done is seen after edge T_CAS.
- R5: An access to a different row raises RAS, holds it high for at least T_PRE cycles and opens the new row. cpu_done is seen after edge T_PRE+T_RCD+T_CAS+1.
- R6: With no row open, an access drops RAS, and CAS falls T_RCD cycles later (never fewer). CAS stays low T_CAS cycles, and cpu_done is seen after edge T_RCD+T_CAS.
- R7: A refresh drops CAS while RAS is high, then drops RAS while CAS is still low. Refreshes recur every REF_PERIOD cycles, and the gap between two refreshes grows beyond that only by the length of the access in flight.
- R8: While a refresh runs, mem_we_n stays high, cpu_done stays low and a pending request waits. The waiting request then completes with correct data.
- R9: A refresh due while a row is open closes that row. The next access to the same row opens it again with a new RAS fall.
- R10: mem_ce_n is low whenever mem_ras_n or mem_cas_n is low.
- R11: cpu_done is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Access request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ROW_W+COL_W | Full address, row in the upper bits |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_addr | output | max(ROW_W,COL_W) | Shared row/column address |
| mem_dq | inout | DW | Bidirectional data bus |

## Verification
The strobe-order and timing properties assume that the requester keeps cpu_we, cpu_addr and cpu_wdata steady from raising cpu_req until cpu_done. They also assume that it drops cpu_req in the cycle right after the pulse, and that every timing parameter is at least one. The bench drives its request port on the falling clock edge and withdraws the request as soon as it sees cpu_done. Its DRAM model drives the data bus only while both strobes are low for a read, so the bus never has two drivers.

// File: rtl/dram_pagectl_pkg.sv
package dram_pagectl_pkg;
  // Sequencer states; every path that raises RAS passes through ST_PRE
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // no row open, strobes idle
    ST_OPEN = 3'd1,  // row held open, waiting for a hit or a close
    ST_PRE  = 3'd2,  // RAS high, precharge wait
    ST_ACT  = 3'd3,  // RAS low, row latched, RAS-to-CAS wait
    ST_CAS  = 3'd4,  // column strobe, data transfer
    ST_RCAS = 3'd5,  // refresh: CAS first
    ST_RRAS = 3'd6   // refresh: then RAS
  } seq_state_t;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int REF_PERIOD = 390
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  output logic pend_o
);
  localparam int REF_W = (REF_PERIOD > 1) ? $clog2(REF_PERIOD) : 1;
  localparam logic [REF_W-1:0] LAST = REF_W'(REF_PERIOD - 1);

  logic [REF_W-1:0] tick_q, tick_d;
  logic             pend_q, pend_d;
  logic             wrap;

  assign wrap = (tick_q == LAST);

  always_comb begin
    tick_d = wrap ? '0 : tick_q + REF_W'(1);
    pend_d = pend_q;
    if (ack_i) pend_d = 1'b0;
    if (wrap)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      pend_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dram_row_tracker.sv
module dram_row_tracker #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             hit_o
);
  logic [ROW_W-1:0] open_row_q;
  logic             valid_q;
  logic             row_en;

  assign row_en = load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (load_i) begin
      valid_q <= 1'b1;
    end else if (clear_i) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_row_q <= '0;
    end else if (row_en) begin
      open_row_q <= row_i;
    end
  end

  assign hit_o = valid_q && (open_row_q == row_i);
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_pagectl_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int MA_W  = 8,
  parameter int T_PRE = 2,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             ref_pend_i,
  input  logic             row_hit_i,
  output logic             ref_ack_o,
  output logic             row_load_o,
  output logic             row_clr_o,
  output logic             cap_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             ce_n_o,
  output logic             we_n_o,
  output logic             dq_oe_o,
  output logic [MA_W-1:0]  ma_o
);
  localparam int MAXT  = (T_PRE > T_RCD) ? ((T_PRE > T_CAS) ? T_PRE : T_CAS)
                                         : ((T_RCD > T_CAS) ? T_RCD : T_CAS);
  localparam int CNT_W = $clog2(MAXT + 1);
  localparam logic [CNT_W-1:0] L_PRE = CNT_W'(T_PRE - 1);
  localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] L_CAS = CNT_W'(T_CAS - 1);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  // next-state process
  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    ref_ack_o  = 1'b0;
    row_load_o = 1'b0;
    row_clr_o  = 1'b0;
    cap_o      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_pend_i) begin
          st_d      = ST_RCAS;
          cnt_d     = L_CAS;
          ref_ack_o = 1'b1;
        end else if (req_i) begin
          st_d       = ST_ACT;
          cnt_d      = L_RCD;
          row_load_o = 1'b1;
        end
      end
      ST_OPEN: begin
        if (ref_pend_i || (req_i && !row_hit_i)) begin
          st_d      = ST_PRE;
          cnt_d     = L_PRE;
          row_clr_o = 1'b1;
        end else if (req_i) begin
          st_d  = ST_CAS;
          cnt_d = L_CAS;
        end
      end
      ST_PRE: begin
        if (cnt_zero) st_d = ST_IDLE;
        else          cnt_d = cnt_q - CNT_W'(1);
      end
      ST_ACT: begin
        if (cnt_zero) begin
          st_d  = ST_CAS;
          cnt_d = L_CAS;
        end else cnt_d = cnt_q - CNT_W'(1);
      end
      ST_CAS: begin
        if (cnt_zero) begin
          st_d  = ST_OPEN;
          cap_o = 1'b1;
        end else cnt_d = cnt_q - CNT_W'(1);
      end
      ST_RCAS: begin
        if (cnt_zero) begin
          st_d  = ST_RRAS;
          cnt_d = L_CAS;
        end else cnt_d = cnt_q - CNT_W'(1);
      end
      ST_RRAS: begin
        if (cnt_zero) begin
          st_d  = ST_PRE;
          cnt_d = L_PRE;
        end else cnt_d = cnt_q - CNT_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // strobe and address decode from the current state
  always_comb begin
    ras_n_o = !(st_q == ST_ACT || st_q == ST_CAS || st_q == ST_OPEN || st_q == ST_RRAS);
    cas_n_o = !(st_q == ST_CAS || st_q == ST_RCAS || st_q == ST_RRAS);
    ce_n_o  = (st_q == ST_IDLE) || (st_q == ST_PRE);
    we_n_o  = !((st_q == ST_CAS) && we_i);
    dq_oe_o = (st_q == ST_CAS) && we_i;
    case (st_q)
      ST_ACT:  ma_o = MA_W'(row_i);
      ST_CAS:  ma_o = MA_W'(col_i);
      default: ma_o = '0;
    endcase
  end
endmodule

// File: rtl/dram_pagectl.sv
module dram_pagectl #(
  parameter int ROW_W      = 8,
  parameter int COL_W      = 8,
  parameter int DW         = 16,
  parameter int T_PRE      = 2,
  parameter int T_RCD      = 2,
  parameter int T_CAS      = 2,
  parameter int REF_PERIOD = 390,
  localparam int AW   = ROW_W + COL_W,
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_wdata,
  output logic [DW-1:0]   cpu_rdata,
  output logic            cpu_done,
  output logic            mem_ce_n,
  output logic            mem_we_n,
  output logic            mem_ras_n,
  output logic            mem_cas_n,
  output logic [MA_W-1:0] mem_addr,
  inout  wire  [DW-1:0]   mem_dq
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic             ref_pend, ref_ack, row_hit, row_load, row_clr;
  logic             cap, dq_oe, rd_en;
  logic             done_q;
  logic [DW-1:0]    rdata_q;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign row = cpu_addr[AW-1:COL_W];
  assign col = cpu_addr[COL_W-1:0];

  dram_refresh_timer #(.REF_PERIOD(REF_PERIOD)) u_ref (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ack_i  (ref_ack),
    .pend_o (ref_pend)
  );

  dram_row_tracker #(.ROW_W(ROW_W)) u_row (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (row_load),
    .clear_i (row_clr),
    .row_i   (row),
    .hit_o   (row_hit)
  );

  dram_seq_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W),
    .T_PRE(T_PRE), .T_RCD(T_RCD), .T_CAS(T_CAS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_i      (cpu_req),
    .we_i       (cpu_we),
    .row_i      (row),
    .col_i      (col),
    .ref_pend_i (ref_pend),
    .row_hit_i  (row_hit),
    .ref_ack_o  (ref_ack),
    .row_load_o (row_load),
    .row_clr_o  (row_clr),
    .cap_o      (cap),
    .ras_n_o    (mem_ras_n),
    .cas_n_o    (mem_cas_n),
    .ce_n_o     (mem_ce_n),
    .we_n_o     (mem_we_n),
    .dq_oe_o    (dq_oe),
    .ma_o       (mem_addr)
  );

  assign mem_dq = dq_oe ? cpu_wdata : 'z;
  assign rd_en  = cap && !cpu_we;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) done_q <= 1'b0;
    else            done_q <= cap;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (rd_en)  rdata_q <= mem_dq;
  end

  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/dram_pagectl_chk.sv
module dram_pagectl_chk #(
  parameter int T_PRE = 2,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic ce_n,
  input logic we_n,
  input logic done
);
  logic [7:0] ras_hi_cnt, act_cnt, cas_lo_cnt;

  // cycles RAS has been high, cycles RAS low with CAS high, cycles CAS low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_hi_cnt <= 8'd255;
      act_cnt    <= 8'd0;
      cas_lo_cnt <= 8'd0;
    end else begin
      if (ras_n) ras_hi_cnt <= (ras_hi_cnt == 8'd255) ? ras_hi_cnt : ras_hi_cnt + 8'd1;
      else       ras_hi_cnt <= 8'd0;
      if (ras_n)       act_cnt <= 8'd0;
      else if (cas_n)  act_cnt <= (act_cnt == 8'd255) ? act_cnt : act_cnt + 8'd1;
      if (!cas_n) cas_lo_cnt <= (cas_lo_cnt == 8'd255) ? cas_lo_cnt : cas_lo_cnt + 8'd1;
      else        cas_lo_cnt <= 8'd0;
    end
  end

  assert_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (ras_hi_cnt >= 8'(T_PRE)));

  assert_ras_to_cas_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n && !$past(ras_n)) |-> (act_cnt >= 8'(T_RCD)));

  assert_cas_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> (cas_lo_cnt >= 8'(T_CAS)));

  assert_cbr_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> !$past(cas_n));

  assert_row_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> !$past(ras_n));

  assert_write_in_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ras_n && !cas_n));

  assert_ce_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> !ce_n);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind dram_pagectl dram_pagectl_chk #(
  .T_PRE(T_PRE), .T_RCD(T_RCD), .T_CAS(T_CAS)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ras_n (mem_ras_n),
  .cas_n (mem_cas_n),
  .ce_n  (mem_ce_n),
  .we_n  (mem_we_n),
  .done  (cpu_done)
);

// File: tb/dram_pagectl_tb.sv
`timescale 1ns/1ps
module dram_pagectl_tb;
  localparam int ROW_W = 4, COL_W = 4, DW = 16;
  localparam int T_PRE = 2, T_RCD = 2, T_CAS = 2, REF_PERIOD = 100;
  localparam int AW = ROW_W + COL_W;
  localparam int MA_W = 4;
  localparam int NV = 10;
  // {we, addr, wdata, expected read data}
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h51, 16'h1111, 16'h0000},
    {1'b1, 8'h52, 16'h2222, 16'h0000},
    {1'b1, 8'h93, 16'h3333, 16'h0000},
    {1'b1, 8'h94, 16'h4444, 16'h0000},
    {1'b0, 8'h51, 16'h0000, 16'h1111},
    {1'b0, 8'h93, 16'h0000, 16'h3333},
    {1'b0, 8'h52, 16'h0000, 16'h2222},
    {1'b1, 8'h52, 16'hBEEF, 16'h0000},
    {1'b0, 8'h52, 16'h0000, 16'hBEEF},
    {1'b0, 8'h94, 16'h0000, 16'h4444}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic cpu_done, mem_ce_n, mem_we_n, mem_ras_n, mem_cas_n;
  logic [MA_W-1:0] mem_addr;
  wire  [DW-1:0] mem_dq;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  dram_pagectl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_PRE(T_PRE), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .REF_PERIOD(REF_PERIOD)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_done(cpu_done), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_addr(mem_addr),
    .mem_dq(mem_dq)
  );

  // ---------------- DRAM model ----------------
  logic [DW-1:0] mem [256];
  logic [ROW_W-1:0] row_l, last_row;
  logic [COL_W-1:0] last_col;
  logic ras_p, cas_p, in_ref;
  int act_cnt, ref_cnt, viol_ref, viol_ce, viol_cbr, gap, max_gap;

  assign mem_dq = (!mem_ras_n && !mem_cas_n && mem_we_n && !in_ref)
                  ? mem[{row_l, mem_addr[COL_W-1:0]}] : 'z;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      ras_p = 1'b1; cas_p = 1'b1; in_ref = 1'b0;
      row_l = '0; last_row = '0; last_col = '0;
      act_cnt = 0; ref_cnt = 0; viol_ref = 0; viol_ce = 0; viol_cbr = 0;
      gap = 0; max_gap = 0;
    end else begin
      gap++;
      if (ras_p && !mem_ras_n && mem_cas_n) begin
        act_cnt++; row_l = mem_addr[ROW_W-1:0]; last_row = row_l;
      end
      if (ras_p && !mem_ras_n && !mem_cas_n && cas_p) viol_cbr++;
      if (cas_p && !mem_cas_n && !mem_ras_n) last_col = mem_addr[COL_W-1:0];
      if (cas_p && !mem_cas_n && mem_ras_n) begin
        if (ref_cnt > 0 && gap > max_gap) max_gap = gap;
        ref_cnt++; in_ref = 1'b1; gap = 0;
      end
      if (!ras_p && mem_ras_n) in_ref = 1'b0;
      if (in_ref && (!mem_we_n || cpu_done)) viol_ref++;
      if ((!mem_ras_n || !mem_cas_n) && mem_ce_n) viol_ce++;
      if (!mem_ras_n && !mem_cas_n && !mem_we_n)
        mem[{row_l, mem_addr[COL_W-1:0]}] = mem_dq;
      ras_p = mem_ras_n; cas_p = mem_cas_n;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = w; cpu_addr = a; cpu_wdata = d; lat = 0;
    do begin
      @(negedge clk); lat++;
    end while (!cpu_done && lat < 300);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    chk(lat < 300, "R3 access completes", lat, 0);
    @(negedge clk);
    chk(cpu_done == 1'b0, "R11 done lasts one cycle", int'(cpu_done), 0);
  endtask

  task automatic wait_refresh();
    int start;
    start = ref_cnt;
    for (int i = 0; i < 400 && ref_cnt == start; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int lat, a0, r0, v0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk({mem_ce_n, mem_we_n, mem_ras_n, mem_cas_n} == 4'hF, "R1 strobes in reset",
        {mem_ce_n, mem_we_n, mem_ras_n, mem_cas_n}, 4'hF);
    chk(cpu_done == 1'b0, "R1 done in reset", int'(cpu_done), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk({mem_ce_n, mem_we_n, mem_ras_n, mem_cas_n} == 4'hF, "R1 strobes idle after reset",
        {mem_ce_n, mem_we_n, mem_ras_n, mem_cas_n}, 4'hF);

    // latency checks aligned just after a refresh
    wait_refresh();
    repeat (8) @(negedge clk);
    a0 = act_cnt;
    access(1'b1, 8'h31, 16'hA1A1, rd, lat);
    chk(lat == T_RCD + T_CAS + 1, "R6 closed-row latency", lat, T_RCD + T_CAS + 1);
    chk(act_cnt == a0 + 1, "R6 one activation", act_cnt, a0 + 1);
    chk(last_row == 4'h3 && last_col == 4'h1, "R2 row/col on pins",
        {last_row, last_col}, 8'h31);
    a0 = act_cnt;
    access(1'b1, 8'h32, 16'hA2A2, rd, lat);
    chk(lat == T_CAS + 1, "R4 page-hit latency", lat, T_CAS + 1);
    chk(act_cnt == a0, "R4 no new RAS on hit", act_cnt, a0);
    a0 = act_cnt;
    access(1'b1, 8'h60, 16'hA6A6, rd, lat);
    chk(lat == T_PRE + T_RCD + T_CAS + 2, "R5 page-miss latency", lat,
        T_PRE + T_RCD + T_CAS + 2);
    chk(act_cnt == a0 + 1, "R5 new row opened", act_cnt, a0 + 1);
    access(1'b0, 8'h31, 16'h0, rd, lat);
    chk(rd == 16'hA1A1, "R3 read back", rd, 16'hA1A1);

    // vector table
    for (int k = 0; k < NV; k++) begin
      access(VEC[k][40], VEC[k][39:32], VEC[k][31:16], rd, lat);
      chk(last_row == VEC[k][39:36] && last_col == VEC[k][35:32], "R2 address split",
          {last_row, last_col}, VEC[k][39:32]);
      if (!VEC[k][40]) chk(rd == VEC[k][15:0], "R3 table read", rd, VEC[k][15:0]);
    end

    // R7: refresh cadence while idle
    r0 = ref_cnt;
    repeat (1000) @(negedge clk);
    chk((ref_cnt - r0) >= 9 && (ref_cnt - r0) <= 11, "R7 refresh count", ref_cnt - r0, 10);
    chk(max_gap <= REF_PERIOD + 20, "R7 refresh gap", max_gap, REF_PERIOD);
    chk(viol_cbr == 0, "R7 CAS before RAS", viol_cbr, 0);

    // R8: request raised during a refresh
    v0 = viol_ref;
    wait_refresh();
    access(1'b0, 8'h94, 16'h0, rd, lat);
    chk(rd == 16'h4444, "R8 data after refresh", rd, 16'h4444);
    chk(lat > T_RCD + T_CAS + 1, "R8 request held off", lat, T_RCD + T_CAS + 2);
    chk(viol_ref == v0, "R8 no access in refresh", viol_ref, v0);

    // R9: refresh closes the open page
    access(1'b0, 8'h51, 16'h0, rd, lat);
    wait_refresh();
    repeat (8) @(negedge clk);
    chk(mem_ras_n == 1'b1, "R9 row closed after refresh", int'(mem_ras_n), 1);
    a0 = act_cnt;
    access(1'b0, 8'h51, 16'h0, rd, lat);
    chk(act_cnt == a0 + 1, "R9 reopen after refresh", act_cnt, a0 + 1);
    chk(rd == 16'h1111, "R9 data intact", rd, 16'h1111);

    // R10: chip enable covers every strobe
    chk(viol_ce == 0, "R10 CE with strobes", viol_ce, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule